// File: doc/BRIEF.md
# Line-21 Caption Data Inserter

This block produces the digital caption-data waveform that a 525-line video encoder adds into its luma path during vertical blanking. The host writes two 7-bit characters for each of the two caption lines. Writes land in a front buffer. At the rise of vertical sync the pair belonging to the field that is starting is copied into a transmit (rear) buffer. An optional auto-clear empties that front pair once it has been taken, so a character is sent only once unless it is written again.

On an enabled caption line, the block waits a programmable number of samples after the leading edge of horizontal sync. It then sends the following, one bit period at a time:
- a clock run-in of seven square cycles;
- three start bits;
- the first character, least significant bit first, followed by its odd-parity bit;
- the second character in the same form.

A data-active flag marks the burst. A 10-bit level code carries either the high data level or zero, and a downstream adder sums it with luma. Analog shaping is left to the filters after this block.

Top module: `cap_line_inserter`

## Requirements
- R1: After reset `dataActive` is 0, `levelOut` is 0, and all four front and rear characters are 0, so a line that is enabled before any load sends 00h characters.
- R2: A burst starts only at a rising edge of `hSync` when either of these holds:
  - `lineNum`==FIRST_LINE (21), `fieldId`=1 and `capMode[0]`=1;
  - `lineNum`==SECOND_LINE (284), `fieldId`=0 and `capMode[1]`=1.
  For `capMode`: 00 disables both lines, 01 enables the first field only, 10 the second field only and 11 both. No other line and field combination ever starts a burst.
- R3: `dataActive` first reads 1 after RUNIN_DELAY+1 clock edges following the edge that samples `hSync` rising. It stays 1 for exactly 26*BIT_SAMPLES cycles.
- R4: Bit periods 0 to 6 form the run-in. In each of them the level is high for the first (BIT_SAMPLES+1)/2 samples and low for the rest.
- R5: Bit periods 7, 8 and 9 are start bits with values 0, 0 and 1.
- R6: Bit periods 10 to 16 carry character 1 bits b0 to b6, and period 17 carries a parity bit that makes the 8 bits odd. Periods 18 to 25 carry character 2 in the same way. Every bit is constant for a whole period.
- R7: A 1 is sent as `levelOut`=HIGH_CODE (default 275, about 50 IRE) and a 0 as `levelOut`=0. Outside a burst `levelOut` is 0.
- R8: `wrEn` with `wrSel` writes `wrData` into a front character:
  - `wrSel`=0: first line, character 1;
  - `wrSel`=1: first line, character 2;
  - `wrSel`=2: second line, character 1;
  - `wrSel`=3: second line, character 2.
  At a `vSync` rise with `fieldId`=1 the first-line pair moves to its rear buffer; with `fieldId`=0 the second-line pair moves. A write without a load does not change what is transmitted.
- R9: When `autoClear`=1, the front pair that is loaded at a `vSync` rise is cleared, so the next load of that pair sends 00h unless the host rewrites it. When `autoClear`=0 the front keeps its value, and repeated loads send the same characters. A write in the same cycle as a load sets the front to the written value, and the rear receives the previous front value.
- R10: A rising edge of `hSync` during a burst is ignored and does not start a second burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| hSync | input | 1 | Horizontal sync, leading edge is the rise |
| vSync | input | 1 | Vertical sync, loads rear buffers on its rise |
| fieldId | input | 1 | 1 for the first field, 0 for the second |
| lineNum | input | LINE_W (10) | Current line number |
| capMode | input | 2 | Per-field insertion enables |
| autoClear | input | 1 | Clear the loaded front pair at load |
| wrEn | input | 1 | Host character write strobe |
| wrSel | input | 2 | Character slot selector |
| wrData | input | 7 | Character value |
| dataActive | output | 1 | High during a caption burst |
| levelOut | output | LEVEL_W (10) | Level code to add into luma |

## Verification
The bench builds the block with BIT_SAMPLES=5 and RUNIN_DELAY=3. This keeps each burst to 130 cycles, so many lines, every mode and many random character pairs fit into a short run. The odd period of 5 samples checks the rounding of the run-in's high half (3 samples high, 2 low). The short delay lets the bench count the exact cycle in which the burst starts and then place a second sync edge inside the burst.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CAP_CHAR_W    = 7;
  localparam int CAP_RUNIN     = 7;
  localparam int CAP_START     = 3;
  localparam int CAP_PRE_BITS  = CAP_RUNIN + CAP_START;
  localparam int CAP_DATA_BITS = 2 * (CAP_CHAR_W + 1);
  localparam int CAP_FRAME     = CAP_PRE_BITS + CAP_DATA_BITS;
  localparam int CAP_IDX_W     = $clog2(CAP_DATA_BITS);

  typedef struct packed {
    logic                 active;
    logic                 fixedBit;
    logic                 fixedVal;
    logic [CAP_IDX_W-1:0] dataIdx;
    logic                 lineSel;
    logic                 loadFirst;
    logic                 loadSecond;
  } capStrobe_t;
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int BIT_SAMPLES = 27,
  parameter int RUNIN_DELAY = 142,
  parameter int LINE_W      = 10,
  parameter int FIRST_LINE  = 21,
  parameter int SECOND_LINE = 284
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSync,
  input  logic              vSync,
  input  logic              fieldId,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [1:0]        capMode,
  output capStrobe_t        stb
);
  localparam int SAMP_W = $clog2(BIT_SAMPLES + 1);
  localparam int DLY_W  = $clog2(RUNIN_DELAY + 1);
  localparam int BIT_W  = $clog2(CAP_FRAME + 1);
  localparam int HALF   = (BIT_SAMPLES + 1) / 2;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} capState_t;

  capState_t         state;
  logic              hPrev, vPrev;
  logic [DLY_W-1:0]  dlyCnt;
  logic [SAMP_W-1:0] sampCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              lineSelQ;

  logic hRise, vRise, hitFirst, hitSecond;

  assign hRise     = hSync & ~hPrev;
  assign vRise     = vSync & ~vPrev;
  assign hitFirst  = (lineNum == LINE_W'(FIRST_LINE)) & fieldId & capMode[0];
  assign hitSecond = (lineNum == LINE_W'(SECOND_LINE)) & ~fieldId & capMode[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      hPrev    <= 1'b0;
      vPrev    <= 1'b0;
      dlyCnt   <= '0;
      sampCnt  <= '0;
      bitCnt   <= '0;
      lineSelQ <= 1'b0;
    end else begin
      hPrev <= hSync;
      vPrev <= vSync;
      case (state)
        ST_IDLE: begin
          if (hRise && (hitFirst || hitSecond)) begin
            state    <= ST_WAIT;
            dlyCnt   <= DLY_W'(RUNIN_DELAY - 1);
            lineSelQ <= hitSecond;
          end
        end
        ST_WAIT: begin
          if (dlyCnt == '0) begin
            state   <= ST_SEND;
            sampCnt <= '0;
            bitCnt  <= '0;
          end else begin
            dlyCnt <= dlyCnt - 1'b1;
          end
        end
        ST_SEND: begin
          if (sampCnt == SAMP_W'(BIT_SAMPLES - 1)) begin
            sampCnt <= '0;
            if (bitCnt == BIT_W'(CAP_FRAME - 1)) begin
              state <= ST_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            sampCnt <= sampCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.active     = (state == ST_SEND);
    stb.fixedBit   = (bitCnt < BIT_W'(CAP_PRE_BITS));
    if (bitCnt < BIT_W'(CAP_RUNIN)) begin
      stb.fixedVal = (sampCnt < SAMP_W'(HALF));
    end else begin
      stb.fixedVal = (bitCnt == BIT_W'(CAP_PRE_BITS - 1));
    end
    if (bitCnt >= BIT_W'(CAP_PRE_BITS)) begin
      stb.dataIdx = CAP_IDX_W'(bitCnt - BIT_W'(CAP_PRE_BITS));
    end else begin
      stb.dataIdx = '0;
    end
    stb.lineSel    = lineSelQ;
    stb.loadFirst  = vRise & fieldId;
    stb.loadSecond = vRise & ~fieldId;
  end
endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int LEVEL_W   = 10,
  parameter int HIGH_CODE = 275
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  capStrobe_t            stb,
  input  logic                  wrEn,
  input  logic [1:0]            wrSel,
  input  logic [CAP_CHAR_W-1:0] wrData,
  input  logic                  autoClear,
  output logic                  dataActive,
  output logic [LEVEL_W-1:0]    levelOut
);
  localparam int SLOTS = 4;

  logic [CAP_CHAR_W-1:0]    front [SLOTS];
  logic [CAP_CHAR_W-1:0]    rear  [SLOTS];
  logic [CAP_DATA_BITS-1:0] frame [2];
  logic                     loadSlot [SLOTS];
  logic                     bitVal;

  function automatic logic [CAP_DATA_BITS-1:0] packPair(
    input logic [CAP_CHAR_W-1:0] c1,
    input logic [CAP_CHAR_W-1:0] c2
  );
    return {~^c2, c2, ~^c1, c1};
  endfunction

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      if (g < 2) begin : g_first
        assign loadSlot[g] = stb.loadFirst;
      end else begin : g_second
        assign loadSlot[g] = stb.loadSecond;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (!rstN) begin
        front[i] <= '0;
        rear[i]  <= '0;
      end else begin
        if (wrEn && (wrSel == 2'(i))) begin
          front[i] <= wrData;
        end else if (loadSlot[i] && autoClear) begin
          front[i] <= '0;
        end
        if (loadSlot[i]) begin
          rear[i] <= front[i];
        end
      end
    end
  end

  assign frame[0] = packPair(rear[0], rear[1]);
  assign frame[1] = packPair(rear[2], rear[3]);

  always_comb begin
    if (stb.fixedBit) begin
      bitVal = stb.fixedVal;
    end else begin
      bitVal = frame[stb.lineSel][stb.dataIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataActive <= 1'b0;
      levelOut   <= '0;
    end else begin
      dataActive <= stb.active;
      levelOut   <= (stb.active && bitVal) ? LEVEL_W'(HIGH_CODE) : '0;
    end
  end
endmodule

// File: rtl/cap_line_inserter.sv
module cap_line_inserter
  import cap_pkg::*;
#(
  parameter int BIT_SAMPLES = 27,
  parameter int RUNIN_DELAY = 142,
  parameter int LINE_W      = 10,
  parameter int FIRST_LINE  = 21,
  parameter int SECOND_LINE = 284,
  parameter int LEVEL_W     = 10,
  parameter int HIGH_CODE   = 275
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hSync,
  input  logic               vSync,
  input  logic               fieldId,
  input  logic [LINE_W-1:0]  lineNum,
  input  logic [1:0]         capMode,
  input  logic               autoClear,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [6:0]         wrData,
  output logic               dataActive,
  output logic [LEVEL_W-1:0] levelOut
);
  capStrobe_t stb;

  cap_ctrl #(
    .BIT_SAMPLES(BIT_SAMPLES),
    .RUNIN_DELAY(RUNIN_DELAY),
    .LINE_W     (LINE_W),
    .FIRST_LINE (FIRST_LINE),
    .SECOND_LINE(SECOND_LINE)
  ) ctrlI (
    .clk    (clk),
    .rstN   (rstN),
    .hSync  (hSync),
    .vSync  (vSync),
    .fieldId(fieldId),
    .lineNum(lineNum),
    .capMode(capMode),
    .stb    (stb)
  );

  cap_datapath #(
    .LEVEL_W  (LEVEL_W),
    .HIGH_CODE(HIGH_CODE)
  ) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .autoClear (autoClear),
    .dataActive(dataActive),
    .levelOut  (levelOut)
  );
endmodule

// File: rtl/cap_line_inserter_chk.sv
module cap_line_inserter_chk
  import cap_pkg::*;
#(
  parameter int BIT_SAMPLES = 27,
  parameter int LEVEL_W     = 10,
  parameter int HIGH_CODE   = 275
) (
  input logic               clk,
  input logic               rstN,
  input logic               dataActive,
  input logic [LEVEL_W-1:0] levelOut,
  input capStrobe_t         stb
);
  localparam int TOTAL = CAP_FRAME * BIT_SAMPLES;

  int runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= 0;
    else runLen <= dataActive ? runLen + 1 : 0;
  end

  // R7: quiet level outside a burst
  p_quiet_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dataActive |-> (levelOut == '0));

  // R7: only two level codes exist
  p_two_levels_r7: assert property (@(posedge clk) disable iff (!rstN)
    (levelOut == '0) || (levelOut == LEVEL_W'(HIGH_CODE)));

  // R3: a burst ends after exactly the frame length
  p_burst_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataActive) |-> (runLen == TOTAL));

  // R3: a burst never runs past the frame length
  p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runLen >= TOTAL) |-> !dataActive);

  // R3: the control's send strobe reaches the output one cycle later
  p_strobe_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.active |=> dataActive);
endmodule

bind cap_line_inserter cap_line_inserter_chk #(
  .BIT_SAMPLES(BIT_SAMPLES),
  .LEVEL_W    (LEVEL_W),
  .HIGH_CODE  (HIGH_CODE)
) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .dataActive(dataActive),
  .levelOut  (levelOut),
  .stb       (stb)
);

// File: tb/cap_line_inserter_tb_top.sv
module cap_line_inserter_tb_top;
  localparam int B     = 5;
  localparam int DLY   = 3;
  localparam int HIGH  = 275;
  localparam int TOTAL = 26 * B;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hSync = 1'b0, vSync = 1'b0, fieldId = 1'b0;
  logic [9:0] lineNum = '0;
  logic [1:0] capMode = 2'b00;
  logic       autoClear = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [6:0] wrData = '0;
  logic       dataActive;
  logic [9:0] levelOut;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [6:0] mFront [4];
  logic [6:0] mRear  [4];

  always #2 clk = ~clk;

  cap_line_inserter #(.BIT_SAMPLES(B), .RUNIN_DELAY(DLY), .HIGH_CODE(HIGH)) dut_i (
    .clk(clk), .rstN(rstN), .hSync(hSync), .vSync(vSync), .fieldId(fieldId),
    .lineNum(lineNum), .capMode(capMode), .autoClear(autoClear), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .dataActive(dataActive), .levelOut(levelOut));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLevel(input int s, input logic [6:0] c1, input logic [6:0] c2);
    int bitN = s / B;
    int ph = s % B;
    logic [15:0] fr = {~^c2, c2, ~^c1, c1};
    bit v;
    if (bitN < 7) v = (ph < (B + 1) / 2);
    else if (bitN < 10) v = (bitN == 9);
    else v = fr[bitN - 10];
    return v ? HIGH : 0;
  endfunction

  task automatic doWrite(input int sel, input logic [6:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'(sel); wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
    mFront[sel] = val;
  endtask

  task automatic doVsync(input bit fid, input bit withWr, input int sel, input logic [6:0] val);
    int base = fid ? 0 : 2;
    @(negedge clk);
    vSync = 1'b1; fieldId = fid;
    if (withWr) begin wrEn = 1'b1; wrSel = 2'(sel); wrData = val; end
    @(negedge clk);
    vSync = 1'b0; wrEn = 1'b0;
    mRear[base] = mFront[base];
    mRear[base + 1] = mFront[base + 1];
    if (autoClear) begin mFront[base] = '0; mFront[base + 1] = '0; end
    if (withWr) mFront[sel] = val;
  endtask

  task automatic runLine(input int ln, input bit fid, input bit expOn,
                         input logic [6:0] c1, input logic [6:0] c2,
                         input bit extraH, input string tag);
    int cnt;
    int ec [3];
    int fa [3];
    int fe [3];
    @(negedge clk);
    lineNum = 10'(ln); fieldId = fid; hSync = 1'b1;
    @(negedge clk);
    hSync = 1'b0;
    cnt = 1;
    while (!dataActive && cnt < DLY + 8) begin
      @(negedge clk);
      cnt++;
    end
    if (!expOn) begin
      check(!dataActive, {"R2 no burst ", tag}, int'(dataActive), 0);
      return;
    end
    check(cnt == DLY + 2, {"R3 start cycle ", tag}, cnt, DLY + 2);
    for (int k = 0; k < 3; k++) begin ec[k] = 0; fa[k] = 0; fe[k] = 0; end
    for (int s = 0; s < TOTAL; s++) begin
      int e, cls;
      if (s > 0) @(negedge clk);
      e = expLevel(s, c1, c2);
      cls = (s / B < 7) ? 0 : ((s / B < 10) ? 1 : 2);
      if (int'(levelOut) != e || !dataActive) begin
        if (ec[cls] == 0) begin fa[cls] = int'(levelOut); fe[cls] = e; end
        ec[cls]++;
      end
      if (extraH && s == 10) begin lineNum = 10'(ln); hSync = 1'b1; end
      if (extraH && s == 11) hSync = 1'b0;
    end
    check(ec[0] == 0, {"R4 run-in ", tag}, fa[0], fe[0]);
    check(ec[1] == 0, {"R5 start bits ", tag}, fa[1], fe[1]);
    check(ec[2] == 0, {"R6 R7 characters ", tag}, fa[2], fe[2]);
    @(negedge clk);
    check(!dataActive && levelOut == 0, {"R3 burst length ", tag}, int'(dataActive), 0);
    if (extraH) begin
      int seen = 0;
      for (int k = 0; k < DLY + 8; k++) begin
        @(negedge clk);
        if (dataActive) seen++;
      end
      check(seen == 0, {"R10 sync in burst ignored ", tag}, seen, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin mFront[i] = '0; mRear[i] = '0; end
    repeat (4) @(negedge clk);
    check(dataActive == 0, "R1 reset dataActive", int'(dataActive), 0);
    check(levelOut == 0, "R1 reset levelOut", int'(levelOut), 0);
    rstN = 1'b1;

    capMode = 2'b11;
    runLine(21, 1'b1, 1'b1, 7'h00, 7'h00, 1'b0, "R1 empty buffers");

    capMode = 2'b00;
    doWrite(0, 7'h41); doWrite(1, 7'h7f);
    doVsync(1'b1, 1'b0, 0, 7'h00);
    runLine(21, 1'b1, 1'b0, 0, 0, 1'b0, "mode 00");

    capMode = 2'b01;
    runLine(21, 1'b1, 1'b1, mRear[0], mRear[1], 1'b0, "R2 mode 01 first");
    runLine(284, 1'b0, 1'b0, 0, 0, 1'b0, "mode 01 second");
    runLine(22, 1'b1, 1'b0, 0, 0, 1'b0, "line 22");
    runLine(21, 1'b0, 1'b0, 0, 0, 1'b0, "line 21 wrong field");

    capMode = 2'b10;
    doWrite(2, 7'h2a); doWrite(3, 7'h01);
    doVsync(1'b0, 1'b0, 0, 7'h00);
    runLine(284, 1'b0, 1'b1, mRear[2], mRear[3], 1'b0, "R2 mode 10 second");
    runLine(21, 1'b1, 1'b0, 0, 0, 1'b0, "mode 10 first");
    runLine(284, 1'b1, 1'b0, 0, 0, 1'b0, "line 284 wrong field");

    capMode = 2'b11;
    doWrite(0, 7'h55); doWrite(1, 7'h33);
    runLine(21, 1'b1, 1'b1, mRear[0], mRear[1], 1'b0, "R8 write without load");
    check(mRear[0] == 7'h41, "R8 model holds old", int'(mRear[0]), 'h41);

    autoClear = 1'b1;
    doVsync(1'b1, 1'b0, 0, 7'h00);
    runLine(21, 1'b1, 1'b1, 7'h55, 7'h33, 1'b0, "R9 clear first use");
    doVsync(1'b1, 1'b0, 0, 7'h00);
    runLine(21, 1'b1, 1'b1, 7'h00, 7'h00, 1'b0, "R9 cleared after use");

    autoClear = 1'b0;
    doWrite(2, 7'h12); doWrite(3, 7'h6e);
    doVsync(1'b0, 1'b0, 0, 7'h00);
    doVsync(1'b0, 1'b0, 0, 7'h00);
    runLine(284, 1'b0, 1'b1, 7'h12, 7'h6e, 1'b0, "R9 hold without clear");

    doWrite(0, 7'h0f);
    doVsync(1'b1, 1'b1, 0, 7'h70);
    runLine(21, 1'b1, 1'b1, 7'h0f, mRear[1], 1'b0, "R9 write at load rear");
    doVsync(1'b1, 1'b0, 0, 7'h00);
    runLine(21, 1'b1, 1'b1, 7'h70, mRear[1], 1'b1, "R9 write at load front");

    for (int it = 0; it < 6; it++) begin
      logic [1:0] md;
      md = 2'(($urandom % 3) + 1);
      capMode = md;
      autoClear = 1'($urandom % 2);
      for (int s = 0; s < 4; s++) doWrite(s, 7'($urandom));
      doVsync(1'b1, 1'b0, 0, 7'h00);
      runLine(21, 1'b1, md[0], mRear[0], mRear[1], 1'b0, "R6 random first");
      doVsync(1'b0, 1'b0, 0, 7'h00);
      runLine(284, 1'b0, md[1], mRear[2], mRear[3], 1'b0, "R6 random second");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule